// File: doc/BRIEF.md
# NAND page Hamming ECC generator

This block sits next to the byte path of a NAND flash controller and builds a Hamming-style error code over the page data as it streams past. Each 256-byte chunk of the page gets its own 3-byte code. The code combines line parity, taken over the byte index, with column parity, taken over the bit positions inside each byte. A correction routine later compares the stored code with a freshly generated one to find and fix a single flipped bit. The default page has two chunks, so it yields six code bytes.

A 2-bit mode field controls the block. A neighbouring control register decodes it from its bits 6:5. Software clears the block, stops it, then enables accumulation before it moves the page. Afterwards it stops accumulation again and switches to read-out. It then pulls the code bytes one at a time through the shared data read path. When done it returns the field to stop. Chunk switching and the cut-off at the end of the page happen inside the block, with no software action.

Top module: `nand_ecc_gen`

## Requirements
- R1: Mode 2'b11 (clear) resets both chunk accumulators and the byte counter. After a clear, every code byte reads 8'hFF and the next accepted byte counts as byte 0 of the page.
- R2: Only mode 2'b01 (run) accepts bytes, one per cycle with `din_valid` high. In mode 2'b00 (stop) and mode 2'b10 (read-out), bytes are ignored and the byte counter does not advance.
- R3: Line parity uses a bit pair for each bit k of the in-chunk index. Code bit 2k covers the odd-weight bytes whose index bit k is 0, and code bit 2k+1 covers those whose index bit k is 1. The lower 8 code bits are the first code byte and bits 15:8 are the second. In the third byte, bits 1:0 are spare ones and bits 7:2 hold column parities 0..5. The column masks are 8'h55, 8'hAA, 8'h33, 8'hCC, 8'h0F and 8'hF0. Every parity bit is stored inverted, so an erased page gives all 8'hFF.
- R4: Accepted bytes 0..255 of the page go to the chunk 0 code. Bytes 256..511 go to the chunk 1 code.
- R5: Bytes offered after the 512th accepted byte are ignored until the next clear.
- R6: In read-out mode, successive reads return, per chunk and chunk 0 first: the second code byte, then the first, then the third.
- R7: Each `rd_strobe` cycle in read-out mode moves to the next code byte. After the sixth byte it wraps to the first. Leaving read-out mode and entering it again restarts at the first byte.
- R8: `rd_data` is 8'h00 whenever the mode is not read-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_mode | input | 2 | 00 stop, 01 run, 10 read-out, 11 clear |
| din_valid | input | 1 | A page byte passes this cycle |
| din | input | 8 | Page byte |
| rd_strobe | input | 1 | Read of the data path in read-out mode |
| rd_data | output | 8 | Current code byte in read-out mode, else zero |

## Verification
The assertions assume that the mode field is held for at least one full cycle between changes. They also assume that `rd_strobe` only matters while read-out is selected. Their counter and pointer invariants hold for any `din_valid` pattern. The bench changes the mode only at the falling clock edge through a task that holds it for a whole cycle. It feeds bytes in every mode, including stop and read-out, so that the ignore rules are exercised. It always passes through stop before entering read-out, following the normal software sequence.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

   typedef enum logic [1:0] {
      ECC_STOP  = 2'b00,
      ECC_RUN   = 2'b01,
      ECC_DUMP  = 2'b10,
      ECC_CLEAR = 2'b11
   } ecc_mode_e;

   localparam int COL_W = 6;

   // Column parities over bit groups of one byte
   function automatic logic [COL_W-1:0] col_parity(input logic [7:0] b);
      logic [COL_W-1:0] c;
      c[0] = ^(b & 8'h55);
      c[1] = ^(b & 8'hAA);
      c[2] = ^(b & 8'h33);
      c[3] = ^(b & 8'hCC);
      c[4] = ^(b & 8'h0F);
      c[5] = ^(b & 8'hF0);
      return c;
   endfunction

endpackage

// File: rtl/ecc_chunk_acc.sv
module ecc_chunk_acc
   import nand_ecc_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 upd,
   input  logic [IDX_W-1:0]     idx,
   input  logic [7:0]           din,
   output logic [2*IDX_W-1:0]   line_par,
   output logic [COL_W-1:0]     col_par
);
   localparam int LINE_W = 2 * IDX_W;

   logic               odd_byte;
   logic [LINE_W-1:0]  flip;

   assign odd_byte = ^din;

   for (genvar k = 0; k < IDX_W; k++) begin : g_pair
      assign flip[2*k]   = odd_byte & ~idx[k];
      assign flip[2*k+1] = odd_byte &  idx[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_par <= '0;
         col_par  <= '0;
      end else if (clear) begin
         line_par <= '0;
         col_par  <= '0;
      end else if (upd) begin
         line_par <= line_par ^ flip;
         col_par  <= col_par ^ col_parity(din);
      end
   end
endmodule

// File: rtl/ecc_readout.sv
module ecc_readout #(
   parameter int NUM_CHUNKS = 2,
   parameter int CODE_BYTES = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              dump,
   input  logic                              rd_strobe,
   input  logic [NUM_CHUNKS*CODE_BYTES*8-1:0] code_flat,
   output logic [7:0]                        rd_byte,
   output logic [$clog2(CODE_BYTES)-1:0]     pos_q,
   output logic [(NUM_CHUNKS>1 ? $clog2(NUM_CHUNKS) : 1)-1:0] chk_q
);
   localparam int PW = $clog2(CODE_BYTES);
   localparam int CW = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;

   logic [PW-1:0] phys;
   logic [7:0]    sel_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         chk_q <= '0;
      end else if (!dump) begin
         pos_q <= '0;
         chk_q <= '0;
      end else if (rd_strobe) begin
         if (pos_q == PW'(CODE_BYTES-1)) begin
            pos_q <= '0;
            chk_q <= (chk_q == CW'(NUM_CHUNKS-1)) ? '0 : chk_q + 1'b1;
         end else begin
            pos_q <= pos_q + 1'b1;
         end
      end
   end

   // Three-byte codes leave in swapped order; other sizes go straight
   if (CODE_BYTES == 3) begin : g_swap
      assign phys = (pos_q == PW'(0)) ? PW'(1) :
                    (pos_q == PW'(1)) ? PW'(0) : PW'(2);
   end else begin : g_straight
      assign phys = pos_q;
   end

   always_comb begin
      sel_byte = code_flat[(int'(chk_q)*CODE_BYTES + int'(phys))*8 +: 8];
   end

   assign rd_byte = dump ? sel_byte : 8'h00;
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
   import nand_ecc_pkg::*;
#(
   parameter int NUM_CHUNKS = 2,
   parameter int IDX_W      = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ecc_mode,
   input  logic       din_valid,
   input  logic [7:0] din,
   input  logic       rd_strobe,
   output logic [7:0] rd_data
);
   localparam int LINE_W     = 2 * IDX_W;
   localparam int CODE_BITS  = LINE_W + COL_W;
   localparam int CODE_BYTES = (CODE_BITS + 7) / 8;
   localparam int PAD_W      = CODE_BYTES * 8 - CODE_BITS;
   localparam int PAGE_BYTES = NUM_CHUNKS << IDX_W;
   localparam int CNT_W      = $clog2(PAGE_BYTES + 1);
   localparam int SEL_W      = CNT_W - IDX_W;
   localparam int PW         = $clog2(CODE_BYTES);
   localparam int CW         = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;
   localparam int FLAT_W     = NUM_CHUNKS * CODE_BYTES * 8;

   if (IDX_W < 3 || IDX_W > 12) begin : g_bad_idx
      $error("nand_ecc_gen: IDX_W must lie in 3..12");
   end
   if (NUM_CHUNKS < 1 || NUM_CHUNKS > 16) begin : g_bad_chunks
      $error("nand_ecc_gen: NUM_CHUNKS must lie in 1..16");
   end

   ecc_mode_e             mode;
   logic [CNT_W-1:0]      cnt_q;
   logic                  accept;
   logic [SEL_W-1:0]      chunk_now;
   logic [FLAT_W-1:0]     code_flat;
   logic [PW-1:0]         ro_pos;
   logic [CW-1:0]         ro_chk;

   assign mode      = ecc_mode_e'(ecc_mode);
   assign accept    = (mode == ECC_RUN) && din_valid &&
                      (cnt_q < CNT_W'(PAGE_BYTES));
   assign chunk_now = cnt_q[CNT_W-1:IDX_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (mode == ECC_CLEAR)   cnt_q <= '0;
      else if (accept)              cnt_q <= cnt_q + 1'b1;
   end

   for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
      logic [LINE_W-1:0] line_par;
      logic [COL_W-1:0]  col_par;
      logic              upd;

      assign upd = accept && (chunk_now == SEL_W'(c));

      ecc_chunk_acc #(.IDX_W(IDX_W)) u_acc (
         .clk      (clk),
         .rst_n    (rst_n),
         .clear    (mode == ECC_CLEAR),
         .upd      (upd),
         .idx      (cnt_q[IDX_W-1:0]),
         .din      (din),
         .line_par (line_par),
         .col_par  (col_par)
      );

      if (PAD_W > 0) begin : g_pad
         assign code_flat[c*CODE_BYTES*8 +: CODE_BYTES*8] =
            {~col_par, {PAD_W{1'b1}}, ~line_par};
      end else begin : g_nopad
         assign code_flat[c*CODE_BYTES*8 +: CODE_BYTES*8] =
            {~col_par, ~line_par};
      end
   end

   ecc_readout #(
      .NUM_CHUNKS (NUM_CHUNKS),
      .CODE_BYTES (CODE_BYTES)
   ) u_ro (
      .clk       (clk),
      .rst_n     (rst_n),
      .dump      (mode == ECC_DUMP),
      .rd_strobe (rd_strobe),
      .code_flat (code_flat),
      .rd_byte   (rd_data),
      .pos_q     (ro_pos),
      .chk_q     (ro_chk)
   );
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk #(
   parameter int CNT_W      = 10,
   parameter int PAGE_BYTES = 512,
   parameter int CODE_BYTES = 3,
   parameter int NUM_CHUNKS = 2,
   parameter int PW         = 2,
   parameter int CW         = 1,
   parameter int FLAT_W     = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        ecc_mode,
   input logic [7:0]        rd_data,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [PW-1:0]     ro_pos,
   input logic [CW-1:0]     ro_chk,
   input logic [FLAT_W-1:0] code_flat
);
   AST_CLEAR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_mode == 2'b11) |=> (cnt_q == '0)); // R1
   AST_CLEAR_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_mode == 2'b11) |=> (&code_flat)); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_mode == 2'b00 || ecc_mode == 2'b10) |=> ($stable(cnt_q) && $stable(code_flat))); // R2
   AST_PAGE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_W'(PAGE_BYTES) && ecc_mode != 2'b11) |=>
      (cnt_q == CNT_W'(PAGE_BYTES) && $stable(code_flat))); // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(PAGE_BYTES)); // R5
   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (ro_pos < PW'(CODE_BYTES)) && (int'(ro_chk) < NUM_CHUNKS)); // R7
   AST_PTR_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_mode != 2'b10) |=> (ro_pos == '0 && ro_chk == '0)); // R7
   AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ecc_mode != 2'b10) |-> (rd_data == 8'h00)); // R8
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(
   .CNT_W      (CNT_W),
   .PAGE_BYTES (PAGE_BYTES),
   .CODE_BYTES (CODE_BYTES),
   .NUM_CHUNKS (NUM_CHUNKS),
   .PW         (PW),
   .CW         (CW),
   .FLAT_W     (FLAT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ecc_mode  (ecc_mode),
   .rd_data   (rd_data),
   .cnt_q     (cnt_q),
   .ro_pos    (ro_pos),
   .ro_chk    (ro_chk),
   .code_flat (code_flat)
);

// File: tb/nand_ecc_gen_tb.sv
module nand_ecc_gen_tb;
   localparam logic [1:0] M_STOP = 2'b00, M_RUN = 2'b01, M_DUMP = 2'b10, M_CLR = 2'b11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ecc_mode = M_STOP;
   logic       din_valid = 1'b0;
   logic [7:0] din = 8'h00;
   logic       rd_strobe = 1'b0;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   nand_ecc_gen u_dut (
      .clk(clk), .rst_n(rst_n), .ecc_mode(ecc_mode), .din_valid(din_valid),
      .din(din), .rd_strobe(rd_strobe), .rd_data(rd_data)
   );

   // {fill, flip index, flip mask, six expected bytes in read order}
   localparam int NV = 7;
   localparam logic [73:0] VEC [NV] = '{
      {8'hFF, 10'd0,     8'h00, 48'hFFFFFF_FFFFFF},
      {8'hFF, 10'd0,     8'h01, 48'hAAAAAB_FFFFFF},
      {8'hFF, 10'd511,   8'h80, 48'hFFFFFF_555557},
      {8'hFF, 10'h1A5,   8'h10, 48'hFFFFFF_66996B},
      {8'h00, 10'd3,     8'h03, 48'hFFFFF3_FFFFFF},
      {8'hFF, 10'd255,   8'h80, 48'h555557_FFFFFF},
      {8'hFF, 10'd256,   8'h01, 48'hFFFFFF_AAAAAB}
   };

   task automatic check8(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic set_mode(input logic [1:0] m);
      ecc_mode = m;
      @(negedge clk);
   endtask

   task automatic feed(input logic [7:0] b);
      din = b;
      din_valid = 1'b1;
      @(negedge clk);
      din_valid = 1'b0;
   endtask

   task automatic read_one(input string req, input logic [7:0] exp);
      #1;
      check8(req, rd_data, exp);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   task automatic read_six(input string req, input logic [47:0] exp);
      set_mode(M_STOP);
      set_mode(M_DUMP);
      for (int i = 0; i < 6; i++) read_one(req, exp[47-8*i -: 8]);
      set_mode(M_STOP);
   endtask

   task automatic run_page(input logic [7:0] fill, input int idx, input logic [7:0] mask);
      set_mode(M_CLR);
      set_mode(M_STOP);
      ecc_mode = M_RUN;
      for (int i = 0; i < 512; i++) feed((i == idx) ? (fill ^ mask) : fill);
      set_mode(M_STOP);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state: quiet bus, erased code
      #1 check8("R8 reset bus", rd_data, 8'h00);
      read_six("R3 reset erased", 48'hFFFFFF_FFFFFF);

      // Table walk: R3 layout, R4 chunk split, R6 byte order
      for (int v = 0; v < NV; v++) begin
         run_page(VEC[v][73:66], int'(VEC[v][65:56]), VEC[v][55:48]);
         read_six($sformatf("R6 R4 R3 vec%0d", v), VEC[v][47:0]);
      end

      // R7: wrap after sixth byte and restart on re-entry
      run_page(8'hFF, 10'h1A5, 8'h10);
      set_mode(M_DUMP);
      for (int i = 0; i < 6; i++) read_one("R7 walk", (i == 3) ? 8'h66 : (i == 4) ? 8'h99 : (i == 5) ? 8'h6B : 8'hFF);
      read_one("R7 wrap", 8'hFF);
      read_one("R7 wrap2", 8'hFF);
      read_one("R7 wrap3", 8'hFF);
      read_one("R7 wrap4", 8'h66);
      set_mode(M_STOP);
      #1 check8("R8 stop bus", rd_data, 8'h00);
      set_mode(M_DUMP);
      read_one("R7 reentry", 8'hFF);
      set_mode(M_STOP);

      // R2: bytes in stop and read-out mode are ignored
      set_mode(M_CLR);
      ecc_mode = M_STOP;
      for (int i = 0; i < 3; i++) feed(8'hFE);
      ecc_mode = M_DUMP;
      for (int i = 0; i < 3; i++) feed(8'hFE);
      #1 check8("R2 dump unchanged", rd_data, 8'hFF);
      set_mode(M_STOP);
      ecc_mode = M_RUN;
      feed(8'hFE);
      read_six("R2 counter held", 48'hAAAAAB_FFFFFF);

      // R1: clear erases the code
      set_mode(M_CLR);
      read_six("R1 cleared", 48'hFFFFFF_FFFFFF);

      // R5: bytes past the page are ignored until clear
      run_page(8'hFF, 0, 8'h00);
      ecc_mode = M_RUN;
      feed(8'hFE);
      feed(8'h01);
      read_six("R5 past page", 48'hFFFFFF_FFFFFF);
      set_mode(M_CLR);
      set_mode(M_STOP);
      ecc_mode = M_RUN;
      feed(8'hFE);
      read_six("R1 R5 counting after clear", 48'hAAAAAB_FFFFFF);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule